// File: doc/BRIEF.md
# Audio Serial Port Master Timing Generator

This block drives the bit clock and frame sync of a stereo audio serial port when the port is the timing master. A single master clock is divided down so that one frame spans exactly one sample period. The sample period is chosen from eight rates by a 3-bit code. A frame is either 64 bit periods long, for one device on the bus, or 128 bit periods long, split into two 64-bit slots so two devices can share the bus.

In 128-bit frames the slot select input picks which half of the frame is this device's data window. In 64-bit frames that same input instead picks the sync style. One style is a single bit-period pulse just before the first data bit. The other keeps sync high through the left word and low through the right word. New settings take effect only at a frame boundary. Any change of the rate code raises a one-cycle calibration request. Reset drives both clock outputs low. Power-down releases them by dropping their output enables.

Top module: `sport_master_timer`

## Requirements
- R1: A frame lasts 128 bit periods when `frame_long_i`=1 and 64 bit periods when it is 0. `bit_cnt_o` counts 0 up to the last bit and then returns to 0.
- R2: Rate code c sets the frame length in master clocks to N: 0→256, 1→384, 2→512, 3→640, 4→768, 5→1024, 6→1280, 7→1536. One bit period is N/128 master clocks in 128-bit frames and N/64 master clocks in 64-bit frames.
- R3: Each bit period starts with `bclk_o` low for floor(P/2) master clocks, followed by `bclk_o` high for ceil(P/2) master clocks. `bit_cnt_o`, `fsync_o` and `slot_active_o` change only on a falling edge of `bclk_o`, so the rising edge is the safe sampling edge.
- R4: Pulse sync applies in 128-bit frames, and in 64-bit frames with `slot_sel_i`=0. In this style `fsync_o` is high for exactly one bit period, the one where `bit_cnt_o` is at the last bit, directly before bit 0.
- R5: Word sync applies in 64-bit frames with `slot_sel_i`=1. In this style `fsync_o` is high for bits 0 to 31 (left word) and low for bits 32 to 63 (right word).
- R6: In 128-bit frames `slot_active_o` is high for bits 0 to 63 when `slot_sel_i`=0 and for bits 64 to 127 when it is 1. In 64-bit frames it is high for all 64 bits.
- R7: While `rst_i`=1, `bclk_o`, `fsync_o` and `slot_active_o` are 0 and both output enables are 1. On the first bit period after release, `bit_cnt_o` shows the last bit of the selected frame.
- R8: While `pwrdn_i`=1 and `rst_i`=0, both output enables are 0 and `bclk_o`, `fsync_o` and `slot_active_o` are 0. On exit, counting restarts as it does after reset.
- R9: `cal_req_o` is 1 for exactly one master clock, in the cycle after the first cycle in which `rate_code_i` differs from its value one cycle earlier. It stays 0 while the code is unchanged.
- R10: A change of `rate_code_i`, `frame_long_i` or `slot_sel_i` does not alter the bit period in progress or the rest of the current frame. It applies from the next bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pwrdn_i | input | 1 | Power-down, active high |
| frame_long_i | input | 1 | 1: 128-bit frame, 0: 64-bit frame |
| slot_sel_i | input | 1 | Slot choice (128-bit) or sync style (64-bit) |
| rate_code_i | input | 3 | Sample-rate divider code |
| bclk_o | output | 1 | Bit clock value |
| bclk_oe_o | output | 1 | Bit clock output enable |
| fsync_o | output | 1 | Frame sync value |
| fsync_oe_o | output | 1 | Frame sync output enable |
| slot_active_o | output | 1 | High during this device's 64-bit data window |
| bit_cnt_o | output | 7 | Bit index within the frame |
| cal_req_o | output | 1 | One-cycle calibration request |

## Verification
A bad phase counter shows up within a single bit period, as a wrong `bclk_o` duty or period. A bad bit counter or a bad latched configuration appears within one frame, at most 1536 master clocks, as a wrong sync position, sync width or window placement. Such a fault also shows as a frame length that differs from N. Change-tracking faults in the rate code show up one master clock after the change, as a missing, stretched or spurious `cal_req_o`. A configuration that leaks in mid-frame alters the very next bit period.

// File: rtl/sport_timer_pkg.sv
package sport_timer_pkg;

   localparam int unsigned RATE_CODE_W = 3;
   localparam int unsigned RATE_CODES  = 1 << RATE_CODE_W;

   typedef logic [RATE_CODE_W-1:0] rate_code_t;

   typedef struct packed {
      logic       long_frame;
      logic       slot_sel;
      rate_code_t code;
   } port_cfg_t;

   typedef enum logic {
      SYNC_PULSE = 1'b0,
      SYNC_WORD  = 1'b1
   } sync_style_t;

   // Master clocks per frame for a rate code
   function automatic int unsigned frame_mclks(input int unsigned code);
      if (code < 4) return 256 + 128 * code;
      return 256 * (code - 1);
   endfunction

endpackage

// File: rtl/sport_cfg_track.sv
module sport_cfg_track
   import sport_timer_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      hold_i,
   input  logic      frame_wrap_i,
   input  port_cfg_t cfg_i,
   output port_cfg_t cfg_o,
   output logic      cal_req_o
);

   port_cfg_t  cfg_q;
   rate_code_t code_prev_q;
   logic       cal_q;

   always_ff @(posedge clk_i) begin
      if (hold_i || frame_wrap_i) cfg_q <= cfg_i;
      code_prev_q <= cfg_i.code;
      if (rst_i) cal_q <= 1'b0;
      else       cal_q <= (cfg_i.code != code_prev_q);
   end

   assign cfg_o     = cfg_q;
   assign cal_req_o = cal_q;

   AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (hold_i)
      (!$past(frame_wrap_i) && !$past(hold_i)) |-> $stable(cfg_q)); // R10

   AST_CAL_ON_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_i.code != $past(cfg_i.code)) |=> cal_req_o); // R9

endmodule

// File: rtl/sport_bit_div.sv
module sport_bit_div #(
   parameter int unsigned PH_W          = 5,
   parameter bit          HIGH_ROUND_UP = 1'b1
) (
   input  logic            clk_i,
   input  logic            hold_i,
   input  logic [PH_W-1:0] period_i,
   output logic            bit_end_o,
   output logic            bclk_lvl_o
);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] low_len;

   generate
      if (HIGH_ROUND_UP) begin : g_high_ceil
         assign low_len = period_i >> 1;
      end else begin : g_high_floor
         assign low_len = period_i - (period_i >> 1);
      end
   endgenerate

   assign bit_end_o  = (ph_q == period_i - PH_W'(1));
   assign bclk_lvl_o = (ph_q >= low_len);

   always_ff @(posedge clk_i) begin
      if (hold_i || bit_end_o) ph_q <= '0;
      else                     ph_q <= ph_q + PH_W'(1);
   end

   AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (hold_i)
      ph_q < period_i); // R2

endmodule

// File: rtl/sport_frame_seq.sv
module sport_frame_seq
   import sport_timer_pkg::*;
#(
   parameter int unsigned SHORT_BITS = 64,
   parameter int unsigned LONG_BITS  = 128,
   parameter int unsigned CNT_W      = 7
) (
   input  logic             clk_i,
   input  logic             hold_i,
   input  logic             bit_end_i,
   input  logic             long_i,
   input  logic             slot_sel_i,
   input  logic             init_long_i,
   output logic [CNT_W-1:0] bit_o,
   output logic             frame_wrap_o,
   output logic             fsync_lvl_o,
   output logic             window_lvl_o
);

   localparam int unsigned SLOTS  = LONG_BITS / SHORT_BITS;
   localparam int unsigned SUB_W  = $clog2(SHORT_BITS);
   localparam int unsigned SLOT_W = CNT_W - SUB_W;
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
   localparam logic [CNT_W-1:0] WORD_BITS  = CNT_W'(SHORT_BITS / 2);

   logic [CNT_W-1:0] bit_q;
   logic [CNT_W-1:0] last_bit;
   logic [SLOTS-1:0] slot_hit;
   sync_style_t      style;

   assign last_bit     = long_i ? LONG_LAST : SHORT_LAST;
   assign frame_wrap_o = bit_end_i && (bit_q == last_bit);

   always_ff @(posedge clk_i) begin
      if (hold_i)         bit_q <= init_long_i ? LONG_LAST : SHORT_LAST;
      else if (bit_end_i) bit_q <= frame_wrap_o ? '0 : bit_q + CNT_W'(1);
   end

   assign style = (!long_i && slot_sel_i) ? SYNC_WORD : SYNC_PULSE;

   always_comb begin
      case (style)
         SYNC_WORD: fsync_lvl_o = (bit_q < WORD_BITS);
         default:   fsync_lvl_o = (bit_q == last_bit);
      endcase
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         assign slot_hit[s] = (bit_q[CNT_W-1:SUB_W] == SLOT_W'(s));
      end
   endgenerate

   assign window_lvl_o = long_i ? slot_hit[slot_sel_i] : 1'b1;
   assign bit_o        = bit_q;

   AST_BIT_MOVES_ON_BIT_END: assert property (@(posedge clk_i) disable iff (hold_i)
      (!$past(bit_end_i) && !$past(hold_i)) |-> $stable(bit_q)); // R3

endmodule

// File: rtl/sport_master_timer.sv
module sport_master_timer
   import sport_timer_pkg::*;
#(
   parameter int unsigned SHORT_BITS    = 64,
   parameter int unsigned LONG_BITS     = 128,
   parameter bit          HIGH_ROUND_UP = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          pwrdn_i,
   input  logic                          frame_long_i,
   input  logic                          slot_sel_i,
   input  logic [RATE_CODE_W-1:0]        rate_code_i,
   output logic                          bclk_o,
   output logic                          bclk_oe_o,
   output logic                          fsync_o,
   output logic                          fsync_oe_o,
   output logic                          slot_active_o,
   output logic [$clog2(LONG_BITS)-1:0]  bit_cnt_o,
   output logic                          cal_req_o
);

   localparam int unsigned SLOTS      = LONG_BITS / SHORT_BITS;
   localparam int unsigned CNT_W      = $clog2(LONG_BITS);
   localparam int unsigned MAX_MCLK   = frame_mclks(RATE_CODES - 1);
   localparam int unsigned MAX_PERIOD = MAX_MCLK / SHORT_BITS;
   localparam int unsigned PH_W       = $clog2(MAX_PERIOD + 1);

   generate
      if (SLOTS != 2 || LONG_BITS != SLOTS * SHORT_BITS) begin : g_bad_slots
         $error("LONG_BITS must be exactly twice SHORT_BITS");
      end
      if (SHORT_BITS % 2 != 0) begin : g_bad_word
         $error("SHORT_BITS must split into two equal words");
      end
      for (genvar c = 0; c < RATE_CODES; c++) begin : g_rate_chk
         if (frame_mclks(c) % LONG_BITS != 0) begin : g_bad_rate
            $error("rate divisor not a multiple of LONG_BITS");
         end
         if (frame_mclks(c) / LONG_BITS < 2) begin : g_short_rate
            $error("bit period below two master clocks");
         end
      end
   endgenerate

   logic             hold;
   port_cfg_t        cfg_in;
   port_cfg_t        cfg_q;
   logic [PH_W-1:0]  period;
   logic             bit_end;
   logic             bclk_lvl;
   logic             frame_wrap;
   logic             fsync_lvl;
   logic             window_lvl;
   logic [CNT_W-1:0] bit_idx;

   assign hold   = rst_i || pwrdn_i;
   assign cfg_in = '{long_frame: frame_long_i, slot_sel: slot_sel_i, code: rate_code_i};

   always_comb begin
      int unsigned mclk;
      mclk   = frame_mclks(32'(cfg_q.code));
      period = cfg_q.long_frame ? PH_W'(mclk / LONG_BITS) : PH_W'(mclk / SHORT_BITS);
   end

   sport_cfg_track u_cfg (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .hold_i       (hold),
      .frame_wrap_i (frame_wrap),
      .cfg_i        (cfg_in),
      .cfg_o        (cfg_q),
      .cal_req_o    (cal_req_o)
   );

   sport_bit_div #(
      .PH_W          (PH_W),
      .HIGH_ROUND_UP (HIGH_ROUND_UP)
   ) u_div (
      .clk_i      (clk_i),
      .hold_i     (hold),
      .period_i   (period),
      .bit_end_o  (bit_end),
      .bclk_lvl_o (bclk_lvl)
   );

   sport_frame_seq #(
      .SHORT_BITS (SHORT_BITS),
      .LONG_BITS  (LONG_BITS),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk_i        (clk_i),
      .hold_i       (hold),
      .bit_end_i    (bit_end),
      .long_i       (cfg_q.long_frame),
      .slot_sel_i   (cfg_q.slot_sel),
      .init_long_i  (frame_long_i),
      .bit_o        (bit_idx),
      .frame_wrap_o (frame_wrap),
      .fsync_lvl_o  (fsync_lvl),
      .window_lvl_o (window_lvl)
   );

   // Reset drives the pins low; power-down releases them
   assign bclk_oe_o     = rst_i || !pwrdn_i;
   assign fsync_oe_o    = rst_i || !pwrdn_i;
   assign bclk_o        = !hold && bclk_lvl;
   assign fsync_o       = !hold && fsync_lvl;
   assign slot_active_o = !hold && window_lvl;
   assign bit_cnt_o     = bit_idx;

   AST_FSYNC_MOVES_WHILE_LOW: assert property (@(posedge clk_i) disable iff (hold)
      (fsync_o != $past(fsync_o)) |-> !bclk_o); // R3

endmodule

// File: tb/sport_master_timer_test.sv
`timescale 1ns/1ps
module sport_master_timer_test;

   typedef struct {
      int frame_clks;
      int bits;
      int hi_clks;
      int edge_ok;
      int sync_first;
      int sync_cnt;
      int win_first;
      int win_cnt;
      bit word;
   } rep_t;

   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       pwrdn_i = 1'b0;
   logic       frame_long_i = 1'b1;
   logic       slot_sel_i = 1'b0;
   logic [2:0] rate_code_i = 3'd0;
   logic       bclk_o, bclk_oe_o, fsync_o, fsync_oe_o, slot_active_o, cal_req_o;
   logic [6:0] bit_cnt_o;

   int   checks = 0;
   int   failures = 0;
   int   pending = 0;
   rep_t exp_q[$];

   always #10 clk = ~clk;

   sport_master_timer uut (
      .clk_i         (clk),
      .rst_i         (rst_i),
      .pwrdn_i       (pwrdn_i),
      .frame_long_i  (frame_long_i),
      .slot_sel_i    (slot_sel_i),
      .rate_code_i   (rate_code_i),
      .bclk_o        (bclk_o),
      .bclk_oe_o     (bclk_oe_o),
      .fsync_o       (fsync_o),
      .fsync_oe_o    (fsync_oe_o),
      .slot_active_o (slot_active_o),
      .bit_cnt_o     (bit_cnt_o),
      .cal_req_o     (cal_req_o)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic rep_t expect_for(input bit lng, input bit sel, input int code);
      rep_t r;
      int   n, f, p;
      n = (code < 4) ? 256 + 128 * code : 256 * (code - 1);
      f = lng ? 128 : 64;
      p = n / f;
      r.frame_clks = n;
      r.bits       = f;
      r.hi_clks    = (p + 1) / 2;
      r.edge_ok    = 1;
      r.word       = !lng && sel;
      r.sync_first = r.word ? 0 : f - 1;
      r.sync_cnt   = r.word ? 32 : 1;
      r.win_first  = (lng && sel) ? 64 : 0;
      r.win_cnt    = 64;
      return r;
   endfunction

   task automatic measure(output rep_t r);
      int   prev_bit = -1;
      int   cur;
      bit   started = 0;
      bit   done = 0;
      logic prev_bclk = 1'b0;
      r = '{default: 0};
      r.edge_ok = 1;
      r.sync_first = -1;
      r.win_first = -1;
      while (!done) begin
         @(negedge clk);
         cur = int'(bit_cnt_o);
         if (!started) begin
            if (prev_bit > 0 && cur == 0) started = 1;
         end else if (cur == 0 && prev_bit != 0) begin
            done = 1;
         end
         if (started && !done) begin
            if (cur != prev_bit) begin
               if (!(prev_bclk && !bclk_o)) r.edge_ok = 0;
               r.bits++;
               if (fsync_o) begin
                  if (r.sync_first < 0) r.sync_first = cur;
                  r.sync_cnt++;
               end
               if (slot_active_o) begin
                  if (r.win_first < 0) r.win_first = cur;
                  r.win_cnt++;
               end
            end
            r.frame_clks++;
            if (cur == 0 && bclk_o) r.hi_clks++;
         end
         prev_bit  = cur;
         prev_bclk = bclk_o;
      end
   endtask

   // Monitor: measures one frame per expected item and compares
   initial begin
      rep_t got, want;
      forever begin
         wait (pending != 0);
         measure(got);
         want = exp_q.pop_front();
         check_eq("R2", "frame length in master clocks", got.frame_clks, want.frame_clks);
         check_eq("R1", "bit periods per frame", got.bits, want.bits);
         check_eq("R3", "bclk high clocks", got.hi_clks, want.hi_clks);
         check_eq("R3", "changes on falling bclk", got.edge_ok, want.edge_ok);
         if (want.word) begin
            check_eq("R5", "word sync first bit", got.sync_first, want.sync_first);
            check_eq("R5", "word sync high bits", got.sync_cnt, want.sync_cnt);
         end else begin
            check_eq("R4", "pulse sync bit", got.sync_first, want.sync_first);
            check_eq("R4", "pulse sync width", got.sync_cnt, want.sync_cnt);
         end
         check_eq("R6", "window first bit", got.win_first, want.win_first);
         check_eq("R6", "window bits", got.win_cnt, want.win_cnt);
         pending--;
      end
   end

   // Driver
   task automatic configure(input bit lng, input bit sel, input int code);
      bit changed;
      @(negedge clk);
      changed      = (code != int'(rate_code_i));
      frame_long_i = lng;
      slot_sel_i   = sel;
      rate_code_i  = 3'(code);
      @(negedge clk);
      if (changed) begin
         check_eq("R9", "calibration pulse after change", int'(cal_req_o), 1);
         @(negedge clk);
         check_eq("R9", "calibration pulse one cycle", int'(cal_req_o), 0);
      end else begin
         check_eq("R9", "no calibration without change", int'(cal_req_o), 0);
      end
      exp_q.push_back(expect_for(lng, sel, code));
      pending++;
      wait (pending == 0);
   endtask

   initial begin
      int n;
      repeat (4) @(negedge clk);
      check_eq("R7", "bclk low in reset", int'(bclk_o), 0);
      check_eq("R7", "fsync low in reset", int'(fsync_o), 0);
      check_eq("R7", "bclk driven in reset", int'(bclk_oe_o), 1);
      check_eq("R7", "fsync driven in reset", int'(fsync_oe_o), 1);
      check_eq("R7", "window low in reset", int'(slot_active_o), 0);
      rst_i = 1'b0;
      @(negedge clk);
      check_eq("R7", "last bit after reset", int'(bit_cnt_o), 127);
      check_eq("R4", "sync pulse before first frame", int'(fsync_o), 1);

      configure(1'b1, 1'b0, 0);
      configure(1'b1, 1'b1, 1);
      configure(1'b1, 1'b0, 3);
      configure(1'b0, 1'b0, 3);
      configure(1'b0, 1'b1, 5);
      configure(1'b1, 1'b0, 7);
      configure(1'b1, 1'b1, 4);
      configure(1'b0, 1'b0, 2);
      configure(1'b0, 1'b1, 6);
      configure(1'b0, 1'b0, 0);

      // R10: a mid-frame rate change leaves the running frame alone
      @(negedge clk);
      while (bit_cnt_o != 7'd10) @(negedge clk);
      rate_code_i = 3'd2;
      @(negedge clk);
      while (bit_cnt_o == 7'd10) @(negedge clk);
      n = 0;
      while (bit_cnt_o == 7'd11) begin
         n++;
         @(negedge clk);
      end
      check_eq("R10", "old bit period kept mid-frame", n, 4);
      exp_q.push_back(expect_for(1'b0, 1'b0, 2));
      pending++;
      wait (pending == 0);

      // R8: power-down
      @(negedge clk);
      pwrdn_i = 1'b1;
      @(negedge clk);
      check_eq("R8", "bclk enable off", int'(bclk_oe_o), 0);
      check_eq("R8", "fsync enable off", int'(fsync_oe_o), 0);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         if (bclk_o || fsync_o || slot_active_o) n++;
         @(negedge clk);
      end
      check_eq("R8", "outputs quiet in power-down", n, 0);
      pwrdn_i = 1'b0;
      @(negedge clk);
      check_eq("R8", "bclk enable back", int'(bclk_oe_o), 1);
      check_eq("R8", "restart at last bit", int'(bit_cnt_o), 63);

      // R7: reset in the middle of a frame
      repeat (37) @(negedge clk);
      rst_i = 1'b1;
      @(negedge clk);
      check_eq("R7", "bclk low on mid-run reset", int'(bclk_o), 0);
      check_eq("R7", "fsync low on mid-run reset", int'(fsync_o), 0);
      check_eq("R7", "enables on in reset", int'(bclk_oe_o & fsync_oe_o), 1);
      rst_i = 1'b0;
      @(negedge clk);
      check_eq("R9", "no calibration across reset", int'(cal_req_o), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule